// File: doc/BRIEF.md
# Output Test Pattern Generator and Port Multiplexer

This block sits at the very end of a sampling data path. It drives four 8-bit output ports and an out-of-range flag. In normal operation the ports carry live samples. When the test pattern is enabled, the block replaces the samples with a fixed word sequence that depends on nothing but the sequence position and the selected output mode. A receiver can then check its capture timing and its lane order without an analog signal.

Each port has its own base word. On some steps a port drives the base word. On the others it drives the bitwise inverse of that word, and the range flag marks the inverted steps. The order of steps depends on the output mode. With the four-port (demultiplexed) arrangement it repeats every five cycles. With the two-port arrangement it repeats every ten cycles. A separate output-reset input holds the sequence at its first step, so several devices or ports can be started together. Every output is registered, so each one changes one clock after the inputs that produce it.

Top module: `test_pattern_mux`

## Requirements
- R1: While `rst_n` is low, all ports read 00h, `rng_o` reads 0, and the sequence position returns to step 0.
- R2: With `pat_en` low, each port and `rng_o` show on the next clock the value that the matching live input had at the previous clock.
- R3: When the pattern is active, the base words are port A 01h, port B 02h, port C 03h and port D 04h. On an inverted step each port drives the bitwise complement of its base word (FEh, FDh, FCh, FBh). `rng_o` is 1 on inverted steps and 0 on base steps.
- R4: With `four_port` high, steps 0 to 4 give base, inverted, base, inverted, base, and the sequence then repeats.
- R5: With `four_port` low, ports C and D follow a 10-step sequence in which steps 1, 4, 5 and 8 are inverted and all other steps are base. Ports A and B drive 00h in this mode.
- R6: While `out_rst` is high, the sequence position stays at step 0 and an enabled pattern drives 00h on all ports with `rng_o` 0. The first clock with `out_rst` low outputs step 0.
- R7: When `pat_en` changes while `out_rst` is low, the multiplexer switches on the next clock. The sequence keeps advancing while the pattern is disabled and is not realigned when it is enabled again.
- R8: When `four_port` changes, the output for that clock uses step 0 of the new mode, and the sequence continues from step 1.
- R9: While the pattern is active, the port and range outputs do not depend on the live data inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_rst | input | 1 | Output reset; holds the sequence at step 0 |
| pat_en | input | 1 | Selects the test pattern instead of live data |
| four_port | input | 1 | 1: four-port sequence (period 5), 0: two-port sequence (period 10) |
| live_a | input | 8 | Live sample for port A |
| live_b | input | 8 | Live sample for port B |
| live_c | input | 8 | Live sample for port C |
| live_d | input | 8 | Live sample for port D |
| live_rng | input | 1 | Live out-of-range flag |
| port_a | output | 8 | Output port A |
| port_b | output | 8 | Output port B |
| port_c | output | 8 | Output port C |
| port_d | output | 8 | Output port D |
| rng_o | output | 1 | Output out-of-range flag |

## Verification
The live inputs receive fresh random values on every cycle. A pass-through run therefore tells a registered copy apart from a stuck or swapped lane, and any leak of live data into an active pattern shows up. The bench runs long stretches in each mode, which separates the period-5 order from the period-10 order and checks the exact positions of the inverted steps. It toggles the enable, changes the mode and pulses the output reset at positions in the middle of a sequence. These cases tell a counter that keeps running apart from one that restarts or stalls, and show whether the mode change and the output reset restart at step 0.

// File: rtl/test_pattern_mux.sv
module test_pattern_mux #(
  parameter int          W      = 8,
  parameter logic [W-1:0] BASE_A = 8'h01,
  parameter logic [W-1:0] BASE_B = 8'h02,
  parameter logic [W-1:0] BASE_C = 8'h03,
  parameter logic [W-1:0] BASE_D = 8'h04
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         out_rst,
  input  logic         pat_en,
  input  logic         four_port,
  input  logic [W-1:0] live_a,
  input  logic [W-1:0] live_b,
  input  logic [W-1:0] live_c,
  input  logic [W-1:0] live_d,
  input  logic         live_rng,
  output logic [W-1:0] port_a,
  output logic [W-1:0] port_b,
  output logic [W-1:0] port_c,
  output logic [W-1:0] port_d,
  output logic         rng_o
);

  localparam logic [3:0]  LAST_4P = 4'd4;
  localparam logic [3:0]  LAST_2P = 4'd9;
  localparam logic [15:0] INV_2P  = 16'b0000_0001_0011_0010;

  logic [3:0] step, eff, last;
  logic       mode_q, inv;
  logic [W-1:0] pa, pb, pc, pd;

  assign eff  = (four_port != mode_q) ? 4'd0 : step;
  assign last = four_port ? LAST_4P : LAST_2P;
  assign inv  = four_port ? eff[0] : INV_2P[eff];

  assign pa = four_port ? (inv ? ~BASE_A : BASE_A) : '0;
  assign pb = four_port ? (inv ? ~BASE_B : BASE_B) : '0;
  assign pc = inv ? ~BASE_C : BASE_C;
  assign pd = inv ? ~BASE_D : BASE_D;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step   <= '0;
      mode_q <= 1'b0;
      port_a <= '0;
      port_b <= '0;
      port_c <= '0;
      port_d <= '0;
      rng_o  <= 1'b0;
    end else begin
      mode_q <= four_port;
      if (out_rst) step <= '0;
      else         step <= (eff == last) ? 4'd0 : eff + 4'd1;
      if (!pat_en) begin
        port_a <= live_a;
        port_b <= live_b;
        port_c <= live_c;
        port_d <= live_d;
        rng_o  <= live_rng;
      end else if (out_rst) begin
        port_a <= '0;
        port_b <= '0;
        port_c <= '0;
        port_d <= '0;
        rng_o  <= 1'b0;
      end else begin
        port_a <= pa;
        port_b <= pb;
        port_c <= pc;
        port_d <= pd;
        rng_o  <= inv;
      end
    end
  end

  assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pat_en |=> (port_c == $past(live_c)) && (rng_o == $past(live_rng)));

  assert_flag_matches_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_en && !out_rst) |=> (port_d == (rng_o ? ~BASE_D : BASE_D)));

  assert_step_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step <= LAST_2P);

  assert_hold_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_rst |=> (step == 4'd0));

  assert_restart_on_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_en && !out_rst && (four_port != mode_q)) |=> !rng_o);

endmodule

// File: tb/test_pattern_mux_tb.sv
module test_pattern_mux_tb;
  logic clk = 1'b0;
  logic rst_n, out_rst, pat_en, four_port, live_rng;
  logic [7:0] live_a, live_b, live_c, live_d;
  logic [7:0] port_a, port_b, port_c, port_d;
  logic rng_o;

  int vectors = 0;
  int errors  = 0;
  string tag = "R1";

  int e_a, e_b, e_c, e_d, e_r;
  int m_step = 0;
  int m_mode = 0;

  always #10 clk = ~clk;

  test_pattern_mux u_dut (
    .clk(clk), .rst_n(rst_n), .out_rst(out_rst), .pat_en(pat_en),
    .four_port(four_port), .live_a(live_a), .live_b(live_b),
    .live_c(live_c), .live_d(live_d), .live_rng(live_rng),
    .port_a(port_a), .port_b(port_b), .port_c(port_c), .port_d(port_d),
    .rng_o(rng_o)
  );

  function automatic bit inverted(int s, int fp);
    if (fp != 0) return (s == 1) || (s == 3);
    return (s == 1) || (s == 4) || (s == 5) || (s == 8);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_a = 0; e_b = 0; e_c = 0; e_d = 0; e_r = 0;
      m_step = 0; m_mode = 0;
    end else begin
      int s;
      int per;
      bit c;
      s = (int'(four_port) != m_mode) ? 0 : m_step;
      m_mode = int'(four_port);
      per = four_port ? 5 : 10;
      c = inverted(s, m_mode);
      if (!pat_en) begin
        e_a = live_a; e_b = live_b; e_c = live_c; e_d = live_d; e_r = live_rng;
      end else if (out_rst) begin
        e_a = 0; e_b = 0; e_c = 0; e_d = 0; e_r = 0;
      end else begin
        e_a = four_port ? (c ? 255 - 1 : 1) : 0;
        e_b = four_port ? (c ? 255 - 2 : 2) : 0;
        e_c = c ? 255 - 3 : 3;
        e_d = c ? 255 - 4 : 4;
        e_r = c;
      end
      m_step = out_rst ? 0 : (s + 1) % per;
    end
  end

  task automatic check_now();
    vectors++;
    if (int'(port_a) != e_a || int'(port_b) != e_b || int'(port_c) != e_c ||
        int'(port_d) != e_d || int'(rng_o) != e_r) begin
      errors++;
      $display("FAIL %s: got a=%02h b=%02h c=%02h d=%02h rng=%0d, expected a=%02h b=%02h c=%02h d=%02h rng=%0d",
               tag, port_a, port_b, port_c, port_d, rng_o, e_a, e_b, e_c, e_d, e_r);
    end
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check_now();
      live_a = 8'($urandom); live_b = 8'($urandom);
      live_c = 8'($urandom); live_d = 8'($urandom);
      live_rng = 1'($urandom);
    end
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; out_rst = 1'b1; pat_en = 1'b1; four_port = 1'b1;
    live_a = 8'hAA; live_b = 8'h55; live_c = 8'h3C; live_d = 8'hC3; live_rng = 1'b1;
    tag = "R1"; run(3);
    rst_n = 1'b1;
    tag = "R6"; run(4);
    tag = "R2"; pat_en = 1'b0; out_rst = 1'b0; run(20);
    tag = "R6"; out_rst = 1'b1; pat_en = 1'b1; run(5);
    out_rst = 1'b0;
    tag = "R4"; run(23);
    tag = "R3"; run(7);
    tag = "R7"; pat_en = 1'b0; run(3); pat_en = 1'b1; run(8);
    tag = "R8"; four_port = 1'b0; run(3);
    tag = "R5"; run(34);
    tag = "R9"; run(12);
    tag = "R7"; pat_en = 1'b0; run(7); pat_en = 1'b1; run(12);
    tag = "R6"; out_rst = 1'b1; run(3); out_rst = 1'b0; run(12);
    tag = "R8"; four_port = 1'b1; run(8); four_port = 1'b0; run(6);
    tag = "R1"; @(negedge clk); #2 rst_n = 1'b0; #3 check_now(); run(2); rst_n = 1'b1;
    tag = "R5"; run(15);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule